// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block tracks the loads that are in flight in an out-of-order core and checks them against every store that executes. Each load is entered when it is dispatched. It is then marked executed when it reads memory. Each entry keeps the load's sequence number and address, and later its data. When a store executes, it presents its sequence number, address and data to every entry at once. Only loads that come after the store in program order, at the same address, take part.

Such a load that has not yet read memory takes the store's data. When it executes, it returns that data in place of the cache value. Such a load that has already read memory has used a stale value, which is an ordering violation. In the cycle of the store, the block reports the oldest violating load as the flush point. The surrounding pipeline then flushes from that point and drives the flush input. The flush input removes every entry from that sequence number onward.

Top module: `lq_order_check`

## Requirements
- R1: After reset the queue is empty. `lq_full` is 0, `viol_valid` is 0, and `exec_hit` is 0 for any sequence number.
- R2: `alloc_valid` fills the lowest-index free entry with `alloc_seq`/`alloc_addr`. After DEPTH (8) allocations `lq_full` is 1. An allocation while full is dropped, so a later execute of that sequence number misses.
- R3: A store takes part only if its sequence number is strictly older than the load's. A store of equal or younger age neither forwards to the load nor flags a violation on it.
- R4: A younger, unexecuted load at the same address captures the store data. When that load later executes, `exec_result` returns the captured data instead of `exec_data`, with `exec_hit` 1. Without a capture, `exec_result` equals `exec_data`.
- R5: A load that has already captured data ignores a store that is not younger than the store it captured from. Such a store neither changes the data nor causes a violation. A younger store than the captured one replaces the data before execution, and flags a violation after execution.
- R6: A younger, address-matching load that has already executed raises `viol_valid` in the same cycle as the store broadcast, with `viol_seq` set to that load's sequence number.
- R7: When several loads violate on one broadcast, `viol_seq` is the one oldest in program order.
- R8: A load that executes in the same cycle as a matching older store broadcast counts as executed and violates.
- R9: A store at a different address has no effect on a load.
- R10: Sequence numbers are 16 bits and compared modulo 2^16: a is younger than b when (a-b) mod 2^16 lies in 1..32767. A store numbered 0xFFFE is therefore older than a load numbered 0x0002.
- R11: `flush_valid` removes, at the next clock edge, every entry whose sequence number is at or after `flush_seq` (modulo order). Older entries stay. Removed entries miss on execute, and their slots become free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Enter a new load |
| alloc_seq | input | 16 | Sequence number of the new load |
| alloc_addr | input | 32 | Address of the new load |
| lq_full | output | 1 | No free entry |
| exec_valid | input | 1 | A load reads memory this cycle |
| exec_seq | input | 16 | Sequence number of the executing load |
| exec_data | input | 32 | Value read from the cache |
| exec_hit | output | 1 | Executing load found in the queue |
| exec_result | output | 32 | Value the load must use |
| st_valid | input | 1 | Store broadcast this cycle |
| st_seq | input | 16 | Store sequence number |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| viol_valid | output | 1 | Ordering violation on this broadcast |
| viol_seq | output | 16 | Oldest violating load (flush point) |
| flush_valid | input | 1 | Flush request |
| flush_seq | input | 16 | Remove entries from this number onward |

## Verification
The bench places sequence numbers across the 0xFFFF/0x0000 boundary. A design that compares them as plain unsigned values would miss the violation there, or keep entries that should have been flushed. It sets up several violators in mixed slot order, so a design that picks by slot index instead of age reports the wrong flush point. It also drives an out-of-order pair of stores to one load. A design without the captured-store filter would overwrite good forwarded data with an older store's value, or flag a false violation. It also drives an execute in the same cycle as a matching broadcast. A design that reads only the registered executed flag would silently forward data into a load that has already returned cache data.

// File: rtl/lq_order_check.sv
module lq_order_check #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [ADDR_W-1:0] alloc_addr,
  output logic              lq_full,
  input  logic              exec_valid,
  input  logic [SEQ_W-1:0]  exec_seq,
  input  logic [DATA_W-1:0] exec_data,
  output logic              exec_hit,
  output logic [DATA_W-1:0] exec_result,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              viol_valid,
  output logic [SEQ_W-1:0]  viol_seq,
  input  logic              flush_valid,
  input  logic [SEQ_W-1:0]  flush_seq
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld, done, fwd;
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [SEQ_W-1:0]  fseq_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  function automatic logic younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return !d[SEQ_W-1] && (d != '0);
  endfunction

  logic [DEPTH-1:0] st_hit, exec_now, bad, cap, kill;
  logic [IDX_W-1:0] free_idx, ex_idx;

  assign lq_full = &vld;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_hit[i]   = st_valid && vld[i] && younger(seq_q[i], st_seq) && (addr_q[i] == st_addr)
                    && !(fwd[i] && !younger(st_seq, fseq_q[i]));
      exec_now[i] = exec_valid && vld[i] && (seq_q[i] == exec_seq);
      bad[i]      = st_hit[i] && (done[i] || exec_now[i]);
      cap[i]      = st_hit[i] && !done[i] && !exec_now[i];
      kill[i]     = flush_valid && vld[i] && !younger(flush_seq, seq_q[i]);
    end
  end

  always_comb begin
    free_idx = '0;
    ex_idx   = '0;
    exec_hit = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = i[IDX_W-1:0];
      if (exec_now[i]) begin
        ex_idx   = i[IDX_W-1:0];
        exec_hit = 1'b1;
      end
    end
  end

  assign exec_result = (exec_hit && fwd[ex_idx]) ? data_q[ex_idx] : exec_data;

  always_comb begin
    viol_valid = 1'b0;
    viol_seq   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (bad[i] && (!viol_valid || younger(viol_seq, seq_q[i]))) begin
        viol_valid = 1'b1;
        viol_seq   = seq_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      done <= '0;
      fwd  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_valid && !lq_full && (free_idx == i[IDX_W-1:0])) begin
          vld[i]    <= 1'b1;
          done[i]   <= 1'b0;
          fwd[i]    <= 1'b0;
          seq_q[i]  <= alloc_seq;
          addr_q[i] <= alloc_addr;
        end else if (kill[i]) begin
          vld[i]  <= 1'b0;
          done[i] <= 1'b0;
          fwd[i]  <= 1'b0;
        end else begin
          if (exec_now[i]) begin
            done[i] <= 1'b1;
            if (!fwd[i]) data_q[i] <= exec_data;
          end
          if (cap[i]) begin
            fwd[i]    <= 1'b1;
            fseq_q[i] <= st_seq;
            data_q[i] <= st_data;
          end
        end
      end
    end
  end

  // R6
  viol_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> st_valid);

  // R3
  viol_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> younger(viol_seq, st_seq));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && lq_full && !flush_valid) |=> ($countones(vld) == $past($countones(vld))));

  // R11
  flush_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !alloc_valid) |=> ($countones(vld) <= $past($countones(vld))));
endmodule

// File: tb/lq_order_check_tb.sv
module lq_order_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_seq = '0;
  logic [31:0] alloc_addr = '0;
  logic        lq_full;
  logic        exec_valid = 1'b0;
  logic [15:0] exec_seq = '0;
  logic [31:0] exec_data = '0;
  logic        exec_hit;
  logic [31:0] exec_result;
  logic        st_valid = 1'b0;
  logic [15:0] st_seq = '0;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        viol_valid;
  logic [15:0] viol_seq;
  logic        flush_valid = 1'b0;
  logic [15:0] flush_seq = '0;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] AA = 32'h0000_3290;
  localparam logic [31:0] AB = 32'h0000_3410;

  always #4 clk = ~clk;

  lq_order_check u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_addr(alloc_addr), .lq_full(lq_full),
    .exec_valid(exec_valid), .exec_seq(exec_seq), .exec_data(exec_data),
    .exec_hit(exec_hit), .exec_result(exec_result),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_data(st_data),
    .viol_valid(viol_valid), .viol_seq(viol_seq),
    .flush_valid(flush_valid), .flush_seq(flush_seq)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc(input logic [15:0] s, input logic [31:0] a);
    alloc_valid = 1'b1; alloc_seq = s; alloc_addr = a;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic exec(input logic [15:0] s, input logic [31:0] d, input logic eh,
                      input logic [31:0] er, input string tag);
    exec_valid = 1'b1; exec_seq = s; exec_data = d;
    #1;
    chk(exec_hit == eh, {tag, " hit"}, 32'(exec_hit), 32'(eh));
    if (eh) chk(exec_result == er, {tag, " result"}, exec_result, er);
    @(negedge clk);
    exec_valid = 1'b0;
  endtask

  task automatic bcast(input logic [15:0] s, input logic [31:0] a, input logic [31:0] d,
                       input logic ev, input logic [15:0] es, input string tag);
    st_valid = 1'b1; st_seq = s; st_addr = a; st_data = d;
    #1;
    chk(viol_valid == ev, {tag, " viol"}, 32'(viol_valid), 32'(ev));
    if (ev) chk(viol_seq == es, {tag, " seq"}, 32'(viol_seq), 32'(es));
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic flush(input logic [15:0] s);
    flush_valid = 1'b1; flush_seq = s;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic t_reset();
    reset_dut();
    #1;
    chk(lq_full == 1'b0, "R1 full", 32'(lq_full), 0);
    chk(viol_valid == 1'b0, "R1 viol", 32'(viol_valid), 0);
    @(negedge clk);
    exec(16'd5, 32'h1, 1'b0, 32'h1, "R1 exec");
  endtask

  task automatic t_fill();
    reset_dut();
    for (int i = 0; i < 8; i++) alloc(16'(10 + i), AA);
    chk(lq_full == 1'b1, "R2 full", 32'(lq_full), 1);
    alloc(16'd99, AA);
    exec(16'd99, 32'h7, 1'b0, 32'h7, "R2 dropped");
    exec(16'd17, 32'h8, 1'b1, 32'h8, "R2 last");
  endtask

  task automatic t_forward();
    reset_dut();
    alloc(16'd20, AA);
    bcast(16'd15, AA, 32'hD1, 1'b0, 16'd0, "R4 bcast");
    exec(16'd20, 32'hCAFE, 1'b1, 32'hD1, "R4 forwarded");
  endtask

  task automatic t_age();
    reset_dut();
    alloc(16'd20, AA);
    bcast(16'd25, AA, 32'hD1, 1'b0, 16'd0, "R3 younger store");
    exec(16'd20, 32'hCAFE, 1'b1, 32'hCAFE, "R3 no forward");
    bcast(16'd20, AA, 32'hD2, 1'b0, 16'd0, "R3 equal seq");
  endtask

  task automatic t_addr();
    reset_dut();
    alloc(16'd20, AA);
    exec(16'd20, 32'h11, 1'b1, 32'h11, "R9 exec");
    bcast(16'd15, AB, 32'hD1, 1'b0, 16'd0, "R9 other addr");
  endtask

  task automatic t_viol();
    reset_dut();
    alloc(16'd20, AA);
    exec(16'd20, 32'h11, 1'b1, 32'h11, "R6 exec");
    bcast(16'd15, AA, 32'hD1, 1'b1, 16'd20, "R6 violation");
  endtask

  task automatic t_oldest();
    reset_dut();
    alloc(16'd30, AA);
    alloc(16'd25, AB);
    alloc(16'd40, AA);
    alloc(16'd27, AA);
    alloc(16'd26, AA);
    exec(16'd30, 32'h1, 1'b1, 32'h1, "R7 e30");
    exec(16'd25, 32'h1, 1'b1, 32'h1, "R7 e25");
    exec(16'd40, 32'h1, 1'b1, 32'h1, "R7 e40");
    exec(16'd27, 32'h1, 1'b1, 32'h1, "R7 e27");
    bcast(16'd10, AA, 32'hD1, 1'b1, 16'd27, "R7 oldest");
  endtask

  task automatic t_override();
    reset_dut();
    alloc(16'd50, AA);
    bcast(16'd40, AA, 32'hD1, 1'b0, 16'd0, "R5 first");
    bcast(16'd45, AA, 32'hD2, 1'b0, 16'd0, "R5 newer");
    bcast(16'd42, AA, 32'hD3, 1'b0, 16'd0, "R5 older");
    exec(16'd50, 32'hCAFE, 1'b1, 32'hD2, "R5 kept newer");
    bcast(16'd44, AA, 32'hD4, 1'b0, 16'd0, "R5 older after exec");
    bcast(16'd47, AA, 32'hD5, 1'b1, 16'd50, "R5 newer after exec");
  endtask

  task automatic t_same();
    reset_dut();
    alloc(16'd60, AA);
    exec_valid = 1'b1; exec_seq = 16'd60; exec_data = 32'h99;
    st_valid = 1'b1; st_seq = 16'd55; st_addr = AA; st_data = 32'hD1;
    #1;
    chk(viol_valid == 1'b1, "R8 viol", 32'(viol_valid), 1);
    chk(viol_seq == 16'd60, "R8 seq", 32'(viol_seq), 60);
    chk(exec_result == 32'h99, "R8 result", exec_result, 32'h99);
    @(negedge clk);
    exec_valid = 1'b0; st_valid = 1'b0;
  endtask

  task automatic t_wrap();
    reset_dut();
    alloc(16'h0002, AA);
    exec(16'h0002, 32'h1, 1'b1, 32'h1, "R10 exec");
    bcast(16'hFFFE, AA, 32'hD1, 1'b1, 16'h0002, "R10 wrap older");
    bcast(16'h0005, AA, 32'hD1, 1'b0, 16'd0, "R10 younger");
  endtask

  task automatic t_flush();
    reset_dut();
    alloc(16'hFFFE, AA);
    alloc(16'hFFFF, AA);
    alloc(16'h0001, AA);
    flush(16'hFFFF);
    exec(16'hFFFE, 32'h5, 1'b1, 32'h5, "R11 older kept");
    exec(16'hFFFF, 32'h5, 1'b0, 32'h5, "R11 flush point");
    exec(16'h0001, 32'h5, 1'b0, 32'h5, "R11 wrapped removed");
    for (int i = 0; i < 7; i++) alloc(16'(16'h0010 + i), AB);
    chk(lq_full == 1'b1, "R11 slots freed", 32'(lq_full), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fill();
        t_forward();
        t_age();
        t_addr();
        t_viol();
        t_oldest();
        t_override();
        t_same();
        t_wrap();
        t_flush();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule